// File: doc/BRIEF.md
# Two-Level Context Address Translator

This block is the address translator of a small demand-paged system. A 21-bit logical address from the processor is first looked up in a segment table. The table is selected by a 4-bit context number and by the top six address bits. The segment entry gives an intermediate segment number and a protection code. That number, joined with the next four address bits, indexes a page table. The page table returns a 12-bit physical page and the space the page lives in. The physical page is placed in front of the 11-bit byte offset to form a 23-bit physical address.

Each access is checked against the rights of its segment for the current privilege state. Each page entry keeps two usage bits, one for "touched" and one for "written". A paging routine can read these bits back to pick pages to evict. A supervisor port loads the context register and every table entry, and reads them back. A request and its checks are resolved in one clock. The registered result appears one cycle later, with a one-hot space select, a segment-fault flag and a page-fault flag.

Top module: `ctx_xlate_mmu`

## Requirements
- R1: After reset the context register is 0, every output is 0, every segment entry has number 0 and protection code 0, and every page entry has page 0, space code 3 and both usage bits clear.
- R2: A supervisor write with target code 0 loads the context from data bits [3:0]. A read with target 0 returns it in bits [3:0]. A request in the same cycle as the context write still uses the old context.
- R3: A request with req_valid high gives out_valid high on the next clock. The segment index is {context, addr[20:15]} and the page index is {segment number, addr[14:11]}. out_paddr is {page, addr[10:0]}. When req_valid is low, every output is 0 on the next clock.
- R4: Access kinds are 0 read, 1 write, 2 execute and 3 reserved; the reserved kind is always refused. req_super high checks the supervisor rights and low checks the user rights. The rights as supervisor/user triples (read, write, execute) are: 0 ---/---, 1 --x/---, 2 r--/---, 3 r-x/---, 4 rw-/---, 5 rwx/---, 6 r--/r--, 7 rw-/r--, 8 r--/rw-, 9 rw-/rw-, 10 rw-/r-x, 11 rw-/rwx, 12 r-x/r-x, 13 rwx/r-x, 14 rwx/--x, 15 rwx/rwx.
- R5: A refused access raises out_seg_fault and never out_page_fault.
- R6: Space codes are 0 on-board memory, 1 off-board memory, 2 off-board I/O and 3 absent. A permitted access to space c < 3 sets out_sel bit c only. A permitted access to space 3 raises out_page_fault.
- R7: A faulting access drives out_sel and out_paddr to 0 and leaves both usage bits of every page entry unchanged.
- R8: A permitted access to a present page sets that page's touched bit; a permitted write also sets its written bit. Both bits stay set until a supervisor write to the entry.
- R9: Target 1 writes the segment entry at cfg_index {context, segment}, with protection in data [3:0] and segment number in [9:4]. Target 2 writes the page entry at cfg_index {segment number, page}, with page in [11:0], space in [13:12], touched in [14] and written in [15]. cfg_re returns the addressed entry in the same layout, other bits 0, on cfg_rdata after the next clock.
- R10: Target 3 writes change no state, and target 3 reads return 0.
- R11: When a supervisor page write and a usage-bit update hit the same entry in one cycle, the supervisor data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Processor request present |
| req_addr | input | 21 | Logical address |
| req_kind | input | 2 | Access kind: read, write, execute, reserved |
| req_super | input | 1 | Supervisor state when high |
| cfg_we | input | 1 | Supervisor write strobe |
| cfg_re | input | 1 | Supervisor read strobe |
| cfg_target | input | 2 | 0 context, 1 segment entry, 2 page entry, 3 reserved |
| cfg_index | input | 10 | Entry index for the segment or page table |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read-back data, valid one clock after cfg_re |
| out_valid | output | 1 | Registered result present |
| out_paddr | output | 23 | Physical address |
| out_sel | output | 3 | One-hot space select |
| out_seg_fault | output | 1 | Protection refused the access |
| out_page_fault | output | 1 | Page marked absent |

## Verification
A table of requests sweeps several protection codes across read, write, execute and the reserved kind, in both privilege states. This separates a correct rights lookup from a wrong triple or a swapped state. The same requests reach pages in every space code, so a wrong select bit or a missed absent page shows up. Usage bits are then read back page by page: a page touched only by faulting requests must stay clear, and only written pages may show the written bit. Directed cases change the context under a live request, send a supervisor write and a usage update to the same entry in one cycle, and write to the reserved target.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

   localparam int PROT_W  = 4;
   localparam int SPACE_W = 2;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [SPACE_W-1:0] {
      SP_ONBOARD = 2'd0,
      SP_OFFMEM  = 2'd1,
      SP_OFFIO   = 2'd2,
      SP_NONE    = 2'd3
   } space_e;

   typedef enum logic [1:0] {
      TGT_CTX  = 2'd0,
      TGT_SEG  = 2'd1,
      TGT_PAGE = 2'd2,
      TGT_RSVD = 2'd3
   } cfg_tgt_e;

   // Rights as {sup_r, sup_w, sup_x, usr_r, usr_w, usr_x}
   function automatic logic [5:0] prot_rights(input logic [PROT_W-1:0] code);
      logic [5:0] r;
      unique case (code)
         4'd0:  r = 6'b000_000;
         4'd1:  r = 6'b001_000;
         4'd2:  r = 6'b100_000;
         4'd3:  r = 6'b101_000;
         4'd4:  r = 6'b110_000;
         4'd5:  r = 6'b111_000;
         4'd6:  r = 6'b100_100;
         4'd7:  r = 6'b110_100;
         4'd8:  r = 6'b100_110;
         4'd9:  r = 6'b110_110;
         4'd10: r = 6'b110_101;
         4'd11: r = 6'b110_111;
         4'd12: r = 6'b101_101;
         4'd13: r = 6'b111_101;
         4'd14: r = 6'b111_001;
         default: r = 6'b111_111;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/xlt_prot_check.sv
module xlt_prot_check
   import xlt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PROT_W-1:0] code,
   input  acc_kind_e         kind,
   input  logic              super_st,
   output logic              allow
);

   logic [5:0] rights;
   logic [2:0] triple;

   always_comb begin
      rights = prot_rights(code);
      triple = super_st ? rights[5:3] : rights[2:0];
      unique case (kind)
         ACC_READ:  allow = triple[2];
         ACC_WRITE: allow = triple[1];
         ACC_EXEC:  allow = triple[0];
         default:   allow = 1'b0;
      endcase
   end

   // R4: code 0 grants nothing
   assert_code0_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0) |-> !allow);
   // R4: reserved kind never granted
   assert_rsvd_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_RSVD) |-> !allow);
   // R4: code 15 grants every defined kind
   assert_full_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 4'hF && kind != ACC_RSVD) |-> allow);

endmodule

// File: rtl/xlt_seg_map.sv
module xlt_seg_map
   import xlt_pkg::*;
#(
   parameter int IDX_W    = 10,
   parameter int SEGNUM_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    lk_idx,
   output logic [SEGNUM_W-1:0] lk_num,
   output logic [PROT_W-1:0]   lk_prot,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [SEGNUM_W-1:0] wr_num,
   input  logic [PROT_W-1:0]   wr_prot,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [SEGNUM_W-1:0] rd_num,
   output logic [PROT_W-1:0]   rd_prot
);

   localparam int DEPTH = 1 << IDX_W;

   logic [SEGNUM_W-1:0] num_q  [DEPTH];
   logic [PROT_W-1:0]   prot_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            num_q[i]  <= '0;
            prot_q[i] <= '0;
         end
      end else if (wr_en) begin
         num_q[wr_idx]  <= wr_num;
         prot_q[wr_idx] <= wr_prot;
      end
   end

   assign lk_num  = num_q[lk_idx];
   assign lk_prot = prot_q[lk_idx];
   assign rd_num  = num_q[rd_idx];
   assign rd_prot = prot_q[rd_idx];

   // R9: an entry not written keeps its protection code
   assert_seg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == lk_idx) |=> (prot_q[$past(lk_idx)] == $past(lk_prot)));

endmodule

// File: rtl/xlt_page_map.sv
module xlt_page_map
   import xlt_pkg::*;
#(
   parameter int IDX_W = 10,
   parameter int PPN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [PPN_W-1:0] lk_ppn,
   output space_e           lk_space,
   input  logic             upd_en,
   input  logic             upd_write,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [PPN_W-1:0] wr_ppn,
   input  space_e           wr_space,
   input  logic             wr_acc,
   input  logic             wr_mod,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [PPN_W-1:0] rd_ppn,
   output space_e           rd_space,
   output logic             rd_acc,
   output logic             rd_mod
);

   localparam int DEPTH = 1 << IDX_W;

   logic [PPN_W-1:0] ppn_q   [DEPTH];
   space_e           space_q [DEPTH];
   logic             acc_q   [DEPTH];
   logic             mod_q   [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ppn_q[i]   <= '0;
            space_q[i] <= SP_NONE;
            acc_q[i]   <= 1'b0;
            mod_q[i]   <= 1'b0;
         end
      end else begin
         if (upd_en) begin
            acc_q[lk_idx] <= 1'b1;
            if (upd_write) mod_q[lk_idx] <= 1'b1;
         end
         // later assignment: supervisor data wins a same-entry collision
         if (wr_en) begin
            ppn_q[wr_idx]   <= wr_ppn;
            space_q[wr_idx] <= wr_space;
            acc_q[wr_idx]   <= wr_acc;
            mod_q[wr_idx]   <= wr_mod;
         end
      end
   end

   assign lk_ppn   = ppn_q[lk_idx];
   assign lk_space = space_q[lk_idx];
   assign rd_ppn   = ppn_q[rd_idx];
   assign rd_space = space_q[rd_idx];
   assign rd_acc   = acc_q[rd_idx];
   assign rd_mod   = mod_q[rd_idx];

   // R8: a granted access leaves the touched bit set
   assert_acc_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !(wr_en && wr_idx == lk_idx)) |=> acc_q[$past(lk_idx)]);
   // R8: a granted write leaves the written bit set
   assert_mod_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_write && !(wr_en && wr_idx == lk_idx)) |=> mod_q[$past(lk_idx)]);
   // R7: with no update and no write, the looked-up usage bits stay put
   assert_stats_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !(wr_en && wr_idx == lk_idx))
         |=> (acc_q[$past(lk_idx)] == $past(acc_q[lk_idx])
              && mod_q[$past(lk_idx)] == $past(mod_q[lk_idx])));

endmodule

// File: rtl/ctx_xlate_mmu.sv
module ctx_xlate_mmu
   import xlt_pkg::*;
#(
   parameter int CTX_W      = 4,
   parameter int SEG_IDX_W  = 6,
   parameter int PAGE_IDX_W = 4,
   parameter int OFFSET_W   = 11,
   parameter int SEGNUM_W   = 6,
   parameter int PPN_W      = 12,
   parameter int CFG_DW     = 16,
   localparam int LA_W      = SEG_IDX_W + PAGE_IDX_W + OFFSET_W,
   localparam int PA_W      = PPN_W + OFFSET_W,
   localparam int SEG_AW    = CTX_W + SEG_IDX_W,
   localparam int PAGE_AW   = SEGNUM_W + PAGE_IDX_W,
   localparam int CFG_IW    = (SEG_AW > PAGE_AW) ? SEG_AW : PAGE_AW,
   localparam int NUM_SEL   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [LA_W-1:0]   req_addr,
   input  logic [1:0]        req_kind,
   input  logic              req_super,
   input  logic              cfg_we,
   input  logic              cfg_re,
   input  logic [1:0]        cfg_target,
   input  logic [CFG_IW-1:0] cfg_index,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [CFG_DW-1:0] cfg_rdata,
   output logic              out_valid,
   output logic [PA_W-1:0]   out_paddr,
   output logic [NUM_SEL-1:0] out_sel,
   output logic              out_seg_fault,
   output logic              out_page_fault
);

   // data-word field positions
   localparam int SEGNUM_LSB = PROT_W;
   localparam int SPACE_LSB  = PPN_W;
   localparam int ACC_BIT    = PPN_W + SPACE_W;
   localparam int MOD_BIT    = ACC_BIT + 1;
   localparam int OFF_HI     = OFFSET_W - 1;
   localparam int PIDX_HI    = OFFSET_W + PAGE_IDX_W - 1;
   localparam int SIDX_HI    = LA_W - 1;

   initial begin : p_elab_checks
      assert (CFG_DW >= MOD_BIT + 1)
         else $error("cfg data too narrow for a page entry");
      assert (CFG_DW >= PROT_W + SEGNUM_W)
         else $error("cfg data too narrow for a segment entry");
      assert (CFG_DW >= CTX_W)
         else $error("cfg data too narrow for the context");
      assert (SEG_AW <= 12 && PAGE_AW <= 12)
         else $error("table depth too large");
   end

   cfg_tgt_e  tgt;
   acc_kind_e kind;
   assign tgt  = cfg_tgt_e'(cfg_target);
   assign kind = acc_kind_e'(req_kind);

   logic [CTX_W-1:0] ctx_q;
   wire ctx_we  = cfg_we && (tgt == TGT_CTX);
   wire seg_we  = cfg_we && (tgt == TGT_SEG);
   wire page_we = cfg_we && (tgt == TGT_PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctx_q <= '0;
      else if (ctx_we) ctx_q <= cfg_wdata[CTX_W-1:0];
   end

   // first level
   logic [SEG_AW-1:0]   seg_idx;
   logic [SEGNUM_W-1:0] seg_num, seg_rd_num;
   logic [PROT_W-1:0]   seg_prot, seg_rd_prot;
   assign seg_idx = {ctx_q, req_addr[SIDX_HI:PIDX_HI+1]};

   xlt_seg_map #(.IDX_W(SEG_AW), .SEGNUM_W(SEGNUM_W)) u_seg (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (seg_idx),
      .lk_num  (seg_num),
      .lk_prot (seg_prot),
      .wr_en   (seg_we),
      .wr_idx  (cfg_index[SEG_AW-1:0]),
      .wr_num  (cfg_wdata[SEGNUM_LSB+SEGNUM_W-1:SEGNUM_LSB]),
      .wr_prot (cfg_wdata[PROT_W-1:0]),
      .rd_idx  (cfg_index[SEG_AW-1:0]),
      .rd_num  (seg_rd_num),
      .rd_prot (seg_rd_prot)
   );

   logic allow;
   xlt_prot_check u_prot (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (seg_prot),
      .kind     (kind),
      .super_st (req_super),
      .allow    (allow)
   );

   // second level
   logic [PAGE_AW-1:0] page_idx;
   logic [PPN_W-1:0]   pg_ppn, pg_rd_ppn;
   space_e             pg_space, pg_rd_space;
   logic               pg_rd_acc, pg_rd_mod;
   logic               ok_c, seg_fault_c, page_fault_c;
   assign page_idx = {seg_num, req_addr[PIDX_HI:OFFSET_W]};

   assign seg_fault_c  = req_valid && !allow;
   assign page_fault_c = req_valid && allow && (pg_space == SP_NONE);
   assign ok_c         = req_valid && allow && (pg_space != SP_NONE);

   xlt_page_map #(.IDX_W(PAGE_AW), .PPN_W(PPN_W)) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (page_idx),
      .lk_ppn    (pg_ppn),
      .lk_space  (pg_space),
      .upd_en    (ok_c),
      .upd_write (kind == ACC_WRITE),
      .wr_en     (page_we),
      .wr_idx    (cfg_index[PAGE_AW-1:0]),
      .wr_ppn    (cfg_wdata[PPN_W-1:0]),
      .wr_space  (space_e'(cfg_wdata[SPACE_LSB+SPACE_W-1:SPACE_LSB])),
      .wr_acc    (cfg_wdata[ACC_BIT]),
      .wr_mod    (cfg_wdata[MOD_BIT]),
      .rd_idx    (cfg_index[PAGE_AW-1:0]),
      .rd_ppn    (pg_rd_ppn),
      .rd_space  (pg_rd_space),
      .rd_acc    (pg_rd_acc),
      .rd_mod    (pg_rd_mod)
   );

   // one-hot space select, one lane per real space
   logic [NUM_SEL-1:0] sel_c;
   for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
      assign sel_c[g] = ok_c && (pg_space == space_e'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_paddr      <= '0;
         out_sel        <= '0;
         out_seg_fault  <= 1'b0;
         out_page_fault <= 1'b0;
      end else begin
         out_valid      <= req_valid;
         out_paddr      <= ok_c ? {pg_ppn, req_addr[OFF_HI:0]} : '0;
         out_sel        <= sel_c;
         out_seg_fault  <= seg_fault_c;
         out_page_fault <= page_fault_c;
      end
   end

   // supervisor read-back
   logic [CFG_DW-1:0] rd_c;
   always_comb begin
      rd_c = '0;
      unique case (tgt)
         TGT_CTX: rd_c[CTX_W-1:0] = ctx_q;
         TGT_SEG: begin
            rd_c[PROT_W-1:0] = seg_rd_prot;
            rd_c[SEGNUM_LSB+SEGNUM_W-1:SEGNUM_LSB] = seg_rd_num;
         end
         TGT_PAGE: begin
            rd_c[PPN_W-1:0] = pg_rd_ppn;
            rd_c[SPACE_LSB+SPACE_W-1:SPACE_LSB] = pg_rd_space;
            rd_c[ACC_BIT] = pg_rd_acc;
            rd_c[MOD_BIT] = pg_rd_mod;
         end
         default: rd_c = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_rdata <= '0;
      else if (cfg_re) cfg_rdata <= rd_c;
   end

   // R3: one result per request, one clock later
   assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_sel == '0 && !out_seg_fault && !out_page_fault && out_paddr == '0));
   // R5: the two fault kinds never coincide
   assert_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_seg_fault && out_page_fault));
   // R6: at most one space selected
   assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_sel));
   // R6: a granted access to a present page selects exactly one space
   assert_sel_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_seg_fault && !out_page_fault) |-> $countones(out_sel) == 1);
   // R7: a fault drives no select and no address
   assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_seg_fault || out_page_fault) |-> (out_sel == '0 && out_paddr == '0));
   // R2: context changes only on a context write
   assert_ctx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctx_we |=> $stable(ctx_q));
   // R10: reserved target leaves the context alone
   assert_rsvd_noctx_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && tgt == TGT_RSVD) |=> $stable(ctx_q));

endmodule

// File: tb/tb_ctx_xlate_mmu.sv
module tb_ctx_xlate_mmu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [20:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_super = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_re = 1'b0;
   logic [1:0]  cfg_target = '0;
   logic [9:0]  cfg_index = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        out_valid;
   logic [22:0] out_paddr;
   logic [2:0]  out_sel;
   logic        out_seg_fault;
   logic        out_page_fault;

   always #4 clk = ~clk;

   ctx_xlate_mmu dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind), .req_super(req_super),
      .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_target(cfg_target), .cfg_index(cfg_index),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .out_valid(out_valid), .out_paddr(out_paddr), .out_sel(out_sel),
      .out_seg_fault(out_seg_fault), .out_page_fault(out_page_fault)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      finish_run();
   end

   // all tasks start and end at a falling edge
   task automatic cfg_wr(input logic [1:0] t, input logic [9:0] idx, input logic [15:0] d);
      cfg_we = 1'b1; cfg_target = t; cfg_index = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic [1:0] t, input logic [9:0] idx, output logic [15:0] d);
      cfg_re = 1'b1; cfg_target = t; cfg_index = idx;
      @(negedge clk);
      d = cfg_rdata;
      cfg_re = 1'b0;
   endtask

   task automatic do_req(input logic sup, input logic [1:0] k, input logic [20:0] a);
      req_valid = 1'b1; req_super = sup; req_kind = k; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [28:0] outs();
      return {out_valid, out_seg_fault, out_page_fault, out_sel, out_paddr};
   endfunction

   typedef struct packed {
      logic        sup;
      logic [1:0]  kind;
      logic [20:0] addr;
      logic        segf;
      logic        pgf;
      logic [2:0]  sel;
      logic [22:0] pa;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 2'd0, {6'd5, 4'd1, 11'h123}, 1'b0, 1'b0, 3'b001, {12'hABC, 11'h123}},
      '{1'b0, 2'd1, {6'd5, 4'd2, 11'h7FF}, 1'b0, 1'b0, 3'b010, {12'h123, 11'h7FF}},
      '{1'b0, 2'd0, {6'd5, 4'd3, 11'h000}, 1'b0, 1'b1, 3'b000, 23'h0},
      '{1'b0, 2'd2, {6'd5, 4'd1, 11'h000}, 1'b1, 1'b0, 3'b000, 23'h0},
      '{1'b1, 2'd0, {6'd6, 4'd0, 11'h010}, 1'b0, 1'b0, 3'b100, {12'h7F0, 11'h010}},
      '{1'b0, 2'd0, {6'd6, 4'd0, 11'h000}, 1'b1, 1'b0, 3'b000, 23'h0},
      '{1'b1, 2'd1, {6'd6, 4'd0, 11'h000}, 1'b1, 1'b0, 3'b000, 23'h0},
      '{1'b0, 2'd2, {6'd7, 4'd0, 11'h004}, 1'b0, 1'b0, 3'b001, {12'h001, 11'h004}},
      '{1'b0, 2'd0, {6'd7, 4'd0, 11'h000}, 1'b1, 1'b0, 3'b000, 23'h0},
      '{1'b1, 2'd1, {6'd7, 4'd0, 11'h008}, 1'b0, 1'b0, 3'b001, {12'h001, 11'h008}},
      '{1'b1, 2'd0, {6'd8, 4'd0, 11'h000}, 1'b1, 1'b0, 3'b000, 23'h0},
      '{1'b0, 2'd2, {6'd9, 4'd4, 11'h400}, 1'b0, 1'b0, 3'b010, {12'hFFF, 11'h400}},
      '{1'b0, 2'd1, {6'd9, 4'd4, 11'h000}, 1'b1, 1'b0, 3'b000, 23'h0},
      '{1'b1, 2'd3, {6'd5, 4'd1, 11'h000}, 1'b1, 1'b0, 3'b000, 23'h0},
      '{1'b1, 2'd1, {6'd5, 4'd3, 11'h000}, 1'b0, 1'b1, 3'b000, 23'h0}
   };

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 outputs after reset", {3'b0, outs()}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_rd(2'd0, 10'd0, d);   chk("R1 context after reset", d, 16'h0000);
      cfg_rd(2'd1, 10'd197, d); chk("R1 segment entry after reset", d, 16'h0000);
      cfg_rd(2'd2, 10'd161, d); chk("R1 page entry after reset", d, 16'h3000);
      do_req(1'b1, 2'd0, {6'd5, 4'd1, 11'h0});
      chk("R1 R4 code 0 refuses after reset", {3'b0, outs()}, {3'b0, 1'b1, 1'b1, 1'b0, 3'b0, 23'h0});

      // setup: context 3, five segments, seven pages
      cfg_wr(2'd0, 10'd0, 16'h0003);
      cfg_wr(2'd1, 10'd197, 16'h00A9);
      cfg_wr(2'd1, 10'd198, 16'h00B2);
      cfg_wr(2'd1, 10'd199, 16'h00CE);
      cfg_wr(2'd1, 10'd200, 16'h00D0);
      cfg_wr(2'd1, 10'd201, 16'h00EC);
      cfg_wr(2'd2, 10'd161, 16'h0ABC);
      cfg_wr(2'd2, 10'd162, 16'h1123);
      cfg_wr(2'd2, 10'd163, 16'h3456);
      cfg_wr(2'd2, 10'd176, 16'h27F0);
      cfg_wr(2'd2, 10'd192, 16'h0001);
      cfg_wr(2'd2, 10'd208, 16'h0200);
      cfg_wr(2'd2, 10'd228, 16'h1FFF);
      cfg_rd(2'd0, 10'd0, d);   chk("R2 context read-back", d, 16'h0003);
      cfg_rd(2'd1, 10'd197, d); chk("R9 segment read-back", d, 16'h00A9);
      cfg_rd(2'd2, 10'd162, d); chk("R9 page read-back", d, 16'h1123);

      // R3 R4 R5 R6: vector table
      for (int i = 0; i < NV; i++) begin
         do_req(VECS[i].sup, VECS[i].kind, VECS[i].addr);
         chk($sformatf("R3 R4 R5 R6 vector %0d", i), {3'b0, outs()},
             {3'b0, 1'b1, VECS[i].segf, VECS[i].pgf, VECS[i].sel, VECS[i].pa});
      end

      // R3: idle cycle returns all zero
      @(negedge clk);
      chk("R3 idle outputs", {3'b0, outs()}, 32'h0);

      // R7 R8: usage bits
      cfg_rd(2'd2, 10'd161, d); chk("R8 read sets touched only", d, 16'h4ABC);
      cfg_rd(2'd2, 10'd162, d); chk("R8 write sets both bits", d, 16'hD123);
      cfg_rd(2'd2, 10'd163, d); chk("R7 page fault leaves bits", d, 16'h3456);
      cfg_rd(2'd2, 10'd176, d); chk("R8 R7 I/O page touched", d, 16'h67F0);
      cfg_rd(2'd2, 10'd192, d); chk("R8 exec then write", d, 16'hC001);
      cfg_rd(2'd2, 10'd208, d); chk("R7 segment fault leaves bits", d, 16'h0200);
      cfg_rd(2'd2, 10'd228, d); chk("R8 exec sets touched only", d, 16'h5FFF);

      // R11: supervisor write and usage update on one entry
      req_valid = 1'b1; req_super = 1'b0; req_kind = 2'd0; req_addr = {6'd5, 4'd1, 11'h0};
      cfg_we = 1'b1; cfg_target = 2'd2; cfg_index = 10'd161; cfg_wdata = 16'h0ABC;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      chk("R11 translation during collision", {29'h0, out_sel}, 32'h1);
      cfg_rd(2'd2, 10'd161, d); chk("R11 supervisor data stored", d, 16'h0ABC);
      do_req(1'b0, 2'd0, {6'd5, 4'd1, 11'h0});
      cfg_rd(2'd2, 10'd161, d); chk("R8 touched set again", d, 16'h4ABC);

      // R2: context switch
      cfg_wr(2'd0, 10'd0, 16'h0004);
      do_req(1'b0, 2'd0, {6'd5, 4'd1, 11'h0});
      chk("R2 new context has empty segment", {31'h0, out_seg_fault}, 32'h1);
      req_valid = 1'b1; req_super = 1'b0; req_kind = 2'd0; req_addr = {6'd5, 4'd1, 11'h55};
      cfg_we = 1'b1; cfg_target = 2'd0; cfg_wdata = 16'h0003;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      chk("R2 same-cycle request uses old context", {31'h0, out_seg_fault}, 32'h1);
      do_req(1'b0, 2'd0, {6'd5, 4'd1, 11'h55});
      chk("R2 R3 request after switch", {3'b0, outs()},
          {3'b0, 1'b1, 1'b0, 1'b0, 3'b001, 12'hABC, 11'h055});

      // R10: reserved target
      cfg_wr(2'd3, 10'd197, 16'hFFFF);
      cfg_rd(2'd1, 10'd197, d); chk("R10 segment unchanged", d, 16'h00A9);
      cfg_rd(2'd0, 10'd0, d);   chk("R10 context unchanged", d, 16'h0003);
      cfg_rd(2'd2, 10'd161, d); chk("R10 page unchanged", d, 16'h4ABC);
      cfg_rd(2'd3, 10'd197, d); chk("R10 reserved read is zero", d, 16'h0000);

      finish_run();
   end

endmodule